// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable register-array model of a serial EEPROM that answers on a two-wire bus. It holds 2048 bytes, split into 128 pages of 16 bytes. A system clock oversamples the bus clock and data lines. The block drives the open-drain data line only through an output-enable, `sda_oe`. When `sda_oe` is 1, the pad pulls SDA low.

A master addresses the block with a select byte. That byte carries a fixed code, the three upper address bits and a direction bit. A write transfer sends a low address byte and then up to a page of data. The data is collected in a page buffer and goes into the array only when the master ends the transfer with a STOP. The STOP also starts a self-timed write interval, counted in system clocks. During that interval the block does not answer its select byte, so a master can poll for completion.

Reads come in two forms. A current-address read continues from an internal pointer. A random read sets the pointer with a dummy write and then issues a repeated START. A write-protect input can shield a parameter-selected region of the array.

Controller states:

| State | Role |
| --- | --- |
| `ST_IDLE` | Waits for a START. |
| `ST_DEV` | Shifts in the select byte. |
| `ST_DACK` | Acknowledge slot for the select byte. |
| `ST_ADDR` | Shifts in the low address byte. |
| `ST_AACK` | Acknowledge slot for the address byte. |
| `ST_WDATA` | Shifts in a write data byte. |
| `ST_WACK` | Acknowledge slot for a write data byte. |
| `ST_RDATA` | Shifts a read byte out. |
| `ST_RACK` | Slot in which the master acknowledges a read byte. |

Transitions:

- STOP sends any state to `ST_IDLE`.
- START sends any state to `ST_DEV`.
- `ST_DEV` goes to `ST_DACK` on a matching select while the block is not busy. Otherwise it goes to `ST_IDLE`.
- `ST_DACK` goes to `ST_RDATA` for a read select and to `ST_ADDR` for a write select.
- `ST_ADDR` goes to `ST_AACK`, and `ST_AACK` goes to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WACK`, and `ST_WACK` goes back to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- `ST_RACK` goes back to `ST_RDATA` when the master acknowledges, and to `ST_IDLE` on a master NACK.

Top module: `eeprom2w_target`

## Requirements
- R1: After reset, and whenever the controller is idle, `sda_oe` is 0.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle. Bytes clocked after it without a new START get no acknowledge. A START (SDA falling while SCL is high) at any point begins a new select byte.
- R3: The select byte is laid out as follows: bits 7:4 must be 1010, bits 3:1 are address bits 10:8, and bit 0 is 1 for a read and 0 for a write. On a match while not busy, the block pulls SDA low during the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next START.
- R4: After a write select, the next byte is acknowledged and sets the address pointer to {select bits 3:1, byte}.
- R5: Write data bytes are acknowledged and held in a page buffer, and the array takes them only at the STOP that ends the transfer. A START before that STOP discards them. A write transfer that ends with no data byte changes nothing and starts no write interval.
- R6: During a write, only address bits 3:0 advance, wrapping within the 16-byte page. A byte past the 16th replaces the earlier byte at the same offset.
- R7: For WRITE_CYCLES clocks after the STOP that commits data, select bytes get no acknowledge. Once the interval has expired, they are acknowledged again.
- R8: Read bytes go out MSB first, and `sda_oe` changes only while SCL is low. A random read is a write select, an address byte, a repeated START and a read select.
- R9: A read select continues from the pointer, which is one past the last byte transferred. Bits 3:1 of a read select are ignored.
- R10: When the master acknowledges a read byte (SDA low in the ninth clock), the next byte follows, and the address wraps from 2047 to 0. A master NACK ends the read with SDA released.
- R11: With `wp_i` at 1, writes into the protected region are acknowledged but leave the array unchanged. With the default parameter, the protected region is pages 64 to 127, i.e. address bit 10 set. Writes below that region still complete.
- R12: With `wp_i` at 0, every address, including the upper half, can be written.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wp_i | input | 1 | Write-protect input, 1 shields the protected region |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume a master that changes SDA only while SCL is low, except to form START or STOP. They also assume each SCL level lasts longer than the synchronizer delay, so that every slave drive change lands in a low phase. They further assume that no START or STOP is issued while the block drives an acknowledge or a read bit.

The bench bit-bangs the bus with SCL phases of eight system clocks. It moves SDA only in the middle of the low phase, and it places START and STOP only where the block has released the line. The wired-AND of the master and slave drivers is modelled explicitly, so the block observes its own drive.

// File: rtl/eeprom2w_pkg.sv
package eeprom2w_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DACK,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } state_e;

    localparam logic [3:0] SELECT_CODE = 4'b1010;
    localparam int unsigned BITS_PER_WORD = 8;

endpackage

// File: rtl/eeprom2w_busmon.sv
module eeprom2w_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_pipe;
    logic [TOP:0] sda_pipe;
    logic         scl_p;
    logic         sda_p;
    logic         scl_s;

    // Idle bus is high, so all stages reset to 1 to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_p    <= scl_pipe[TOP];
            sda_p    <= sda_pipe[TOP];
        end
    end

    assign scl_s     = scl_pipe[TOP];
    assign sda_s     = sda_pipe[TOP];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/eeprom2w_wtimer.sv
module eeprom2w_wtimer #(
    parameter int unsigned CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start_i) begin
            remain <= CW'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign busy_o = (remain != '0);

endmodule

// File: rtl/eeprom2w_pagebuf.sv
module eeprom2w_pagebuf #(
    parameter  int LANE_W = 4,
    localparam int LANES  = 1 << LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [7:0]        byte_i,
    output logic [LANES*8-1:0] data_o,
    output logic [LANES-1:0]  mask_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] byte_q;
        logic       vld_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else if (clr_i) begin
                vld_q  <= 1'b0;
            end else if (wr_i && lane_i == LANE_W'(g)) begin
                byte_q <= byte_i;
                vld_q  <= 1'b1;
            end
        end

        assign data_o[g*8 +: 8] = byte_q;
        assign mask_o[g]        = vld_q;
    end

endmodule

// File: rtl/eeprom2w_array.sv
module eeprom2w_array #(
    parameter  int ADDR_W = 11,
    parameter  int LANE_W = 4,
    localparam int LANES  = 1 << LANE_W,
    localparam int PAGE_W = ADDR_W - LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic               clk,
    input  logic               we_i,
    input  logic [PAGE_W-1:0]  page_i,
    input  logic [LANES*8-1:0] data_i,
    input  logic [LANES-1:0]   mask_i,
    input  logic [ADDR_W-1:0]  raddr_i,
    output logic [7:0]         rdata_o
);
    logic [7:0] mem [DEPTH];

    // A whole page commits in one clock; only lanes with a buffered byte change.
    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int l = 0; l < LANES; l++) begin
                if (mask_i[l]) begin
                    mem[{page_i, LANE_W'(l)}] <= data_i[l*8 +: 8];
                end
            end
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/eeprom2w_target.sv
module eeprom2w_target
    import eeprom2w_pkg::*;
#(
    parameter int          ADDR_W          = 11,
    parameter int          LANE_W          = 4,
    parameter int unsigned WRITE_CYCLES    = 250000,
    parameter bit          PROT_UPPER_HALF = 1'b1,
    parameter int          SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);
    localparam int HI_W   = ADDR_W - 8;
    localparam int PAGE_W = ADDR_W - LANE_W;
    localparam int LANES  = 1 << LANE_W;

    state_e state, state_n;

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [HI_W-1:0]   hi_q;
    logic              rd_q;
    logic [ADDR_W-1:0] ptr;
    logic [6:0]        txsh;
    logic              mack;
    logic              busy;
    logic              dev_ok;
    logic              byte_done;
    logic              pb_wr, pb_clr;
    logic [LANES*8-1:0] pb_data;
    logic [LANES-1:0]  pb_mask;
    logic              commit_en;
    logic              region_hit;
    logic              mem_we;
    logic [7:0]        mem_rdata;

    eeprom2w_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eeprom2w_wtimer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit_en),
        .busy_o  (busy)
    );

    eeprom2w_pagebuf #(.LANE_W(LANE_W)) u_pbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pb_clr),
        .wr_i   (pb_wr),
        .lane_i (ptr[LANE_W-1:0]),
        .byte_i (shreg),
        .data_o (pb_data),
        .mask_o (pb_mask)
    );

    eeprom2w_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .page_i  (ptr[ADDR_W-1:LANE_W]),
        .data_i  (pb_data),
        .mask_i  (pb_mask),
        .raddr_i (ptr),
        .rdata_o (mem_rdata)
    );

    // Protected region selection.
    if (PROT_UPPER_HALF) begin : g_prot_upper
        assign region_hit = ptr[ADDR_W-1];
    end else begin : g_prot_full
        assign region_hit = 1'b1;
    end

    assign dev_ok    = (shreg[7:4] == SELECT_CODE) && !busy;
    assign byte_done = scl_fall && (bit_cnt == 4'(BITS_PER_WORD));
    assign pb_wr     = (state == ST_WDATA) && byte_done && !start_det && !stop_det;
    assign pb_clr    = start_det | stop_det;
    assign commit_en = stop_det && (pb_mask != '0);
    assign mem_we    = commit_en && !(wp_i && region_hit);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next-state logic.
    always_comb begin
        state_n = state;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE:  state_n = ST_IDLE;
                ST_DEV:   if (byte_done) state_n = dev_ok ? ST_DACK : ST_IDLE;
                ST_DACK:  if (scl_fall)  state_n = rd_q ? ST_RDATA : ST_ADDR;
                ST_ADDR:  if (byte_done) state_n = ST_AACK;
                ST_AACK:  if (scl_fall)  state_n = ST_WDATA;
                ST_WDATA: if (byte_done) state_n = ST_WACK;
                ST_WACK:  if (scl_fall)  state_n = ST_WDATA;
                ST_RDATA: if (scl_fall && bit_cnt == 4'd7) state_n = ST_RACK;
                ST_RACK:  if (scl_fall)  state_n = mack ? ST_RDATA : ST_IDLE;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // Shift, count and pointer datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            hi_q    <= '0;
            rd_q    <= 1'b0;
            ptr     <= '0;
            txsh    <= '0;
            mack    <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            case (state)
                ST_DEV, ST_ADDR, ST_WDATA: begin
                    if (scl_rise && bit_cnt != 4'(BITS_PER_WORD)) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        if (state == ST_DEV && dev_ok) begin
                            rd_q <= shreg[0];
                            if (!shreg[0]) hi_q <= shreg[HI_W:1];
                        end
                        if (state == ST_ADDR) begin
                            ptr <= {hi_q, shreg};
                        end
                        if (state == ST_WDATA) begin
                            ptr[LANE_W-1:0] <= ptr[LANE_W-1:0] + LANE_W'(1);
                        end
                    end
                end
                ST_DACK, ST_AACK, ST_WACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (state == ST_DACK && rd_q) begin
                            txsh <= mem_rdata[6:0];
                            ptr  <= ptr + ADDR_W'(1);
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        txsh    <= {txsh[5:0], 1'b0};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack <= ~sda_s;
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (mack) begin
                            txsh <= mem_rdata[6:0];
                            ptr  <= ptr + ADDR_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Output drive: changes only on a detected SCL fall, or release on START/STOP.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
        end else if (start_det || stop_det) begin
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_DEV:            if (byte_done) sda_oe <= dev_ok;
                ST_ADDR, ST_WDATA: if (byte_done) sda_oe <= 1'b1;
                ST_DACK:           if (scl_fall)  sda_oe <= rd_q & ~mem_rdata[7];
                ST_AACK, ST_WACK:  if (scl_fall)  sda_oe <= 1'b0;
                ST_RDATA:          if (scl_fall)  sda_oe <= (bit_cnt == 4'd7) ? 1'b0 : ~txsh[6];
                ST_RACK:           if (scl_fall)  sda_oe <= mack & ~mem_rdata[7];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/eeprom2w_checks.sv
module eeprom2w_checks
    import eeprom2w_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   scl_i,
    input logic   sda_oe,
    input logic   busy,
    input state_e state,
    input logic   stop_det,
    input logic   commit_en
);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe); // R1

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i); // R8

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DACK && sda_oe) |-> !busy); // R7

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det)); // R5

    AST_COMMIT_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> !busy); // R7

    AST_MASTER_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK) |-> !sda_oe); // R10

endmodule

bind eeprom2w_target eeprom2w_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .state     (state),
    .stop_det  (stop_det),
    .commit_en (commit_en)
);

// File: tb/eeprom2w_target_test.sv
module eeprom2w_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam int WCYC       = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int n_checks = 0;
    int n_err = 0;

    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    eeprom2w_target #(.WRITE_CYCLES(WCYC)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    function automatic logic [7:0] pat(input int a, input int t);
        return 8'(a * 5 + t * 37 + 3);
    endfunction

    function automatic logic [7:0] dev(input int a, input bit rw);
        return {4'b1010, 3'(a >> 8), rw};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input bit b);
        hw(H/2); m_sda = b; hw(H/2);
        m_scl = 1'b1; hw(H);
        m_scl = 1'b0;
    endtask

    task automatic get_bit(output bit b);
        m_sda = 1'b1; hw(H);
        m_scl = 1'b1; hw(H/2);
        b = sda_line;
        hw(H/2);
        m_scl = 1'b0;
    endtask

    task automatic start_c();
        hw(H/2); m_sda = 1'b1; hw(H/2);
        m_scl = 1'b1; hw(H);
        m_sda = 1'b0; hw(H);
        m_scl = 1'b0;
    endtask

    task automatic stop_c();
        hw(H/2); m_sda = 1'b0; hw(H/2);
        m_scl = 1'b1; hw(H);
        m_sda = 1'b1; hw(H);
    endtask

    task automatic send(input logic [7:0] v, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(s);
        ack = !s;
    endtask

    task automatic recv(input bit ack, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            get_bit(s);
            v[i] = s;
        end
        put_bit(!ack);
        m_sda = 1'b1;
    endtask

    task automatic wr(input int a, input int n, input bit wait_done, input string req);
        bit ack;
        start_c();
        send(dev(a, 1'b0), ack); chk({req, " select ack"}, ack, 1);
        send(8'(a), ack);        chk({req, " address ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            send(wbuf[k], ack);  chk({req, " data ack"}, ack, 1);
        end
        stop_c();
        if (wait_done) hw(WCYC + 40);
    endtask

    task automatic rd(input int a, input int n, input string req);
        bit ack;
        start_c();
        send(dev(a, 1'b0), ack); chk({req, " dummy select ack"}, ack, 1);
        send(8'(a), ack);        chk({req, " read address ack"}, ack, 1);
        start_c();
        send(dev(0, 1'b1), ack); chk({req, " read select ack"}, ack, 1);
        for (int k = 0; k < n; k++) recv(k != n - 1, rbuf[k]);
        stop_c();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        bit ack;
        logic [7:0] b;

        hw(5);
        chk("R1 oe in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        hw(20);
        chk("R1 oe idle after reset", int'(sda_oe), 0);

        // R3 R4 R5 R7: short write, busy polling
        for (int k = 0; k < 3; k++) wbuf[k] = pat(16'h123 + k, 1);
        wr(16'h123, 3, 1'b0, "R5");
        start_c(); send(dev(0, 1'b0), ack); stop_c();
        chk("R7 select during write interval", ack, 0);
        hw(WCYC + 40);
        start_c(); send(dev(0, 1'b0), ack); stop_c();
        chk("R7 select after write interval", ack, 1);

        // R8 random read
        rd(16'h123, 2, "R8");
        chk("R8 random byte 0", rbuf[0], pat(16'h123, 1));
        chk("R8 random byte 1", rbuf[1], pat(16'h124, 1));

        // R9 current-address read, select bits 3:1 set to ignored value
        start_c(); send(8'b1010_1111, ack); chk("R9 current select ack", ack, 1);
        recv(1'b0, b); stop_c();
        chk("R9 current address byte", b, pat(16'h125, 1));

        // R6 wrap inside page
        for (int k = 0; k < 4; k++) wbuf[k] = pat(k, 2);
        wr(16'h2FE, 4, 1'b1, "R6");
        rd(16'h2F0, 2, "R6");
        chk("R6 wrapped lane 0", rbuf[0], pat(2, 2));
        chk("R6 wrapped lane 1", rbuf[1], pat(3, 2));
        rd(16'h2FE, 2, "R6");
        chk("R6 lane 14", rbuf[0], pat(0, 2));
        chk("R6 lane 15", rbuf[1], pat(1, 2));

        // R6 overflow: 18 bytes into one page, sweep every lane
        for (int k = 0; k < 18; k++) wbuf[k] = pat(k, 3);
        wr(16'h050, 18, 1'b1, "R6");
        rd(16'h050, 16, "R6");
        for (int l = 0; l < 16; l++)
            chk("R6 overflow lane", rbuf[l], (l < 2) ? pat(16 + l, 3) : pat(l, 3));

        // R5 restart discards buffered data, no write interval starts
        wbuf[0] = 8'h11;
        wr(16'h200, 1, 1'b1, "R5");
        start_c();
        send(dev(16'h200, 1'b0), ack); chk("R5 abort select ack", ack, 1);
        send(8'h00, ack);              chk("R5 abort address ack", ack, 1);
        send(8'h99, ack);              chk("R5 abort data ack", ack, 1);
        start_c(); stop_c();
        start_c(); send(dev(0, 1'b0), ack); stop_c();
        chk("R5 no interval after discarded data", ack, 1);
        rd(16'h200, 1, "R5");
        chk("R5 discarded byte not stored", rbuf[0], 8'h11);

        // R5 address-only write starts no interval
        start_c(); send(dev(16'h300, 1'b0), ack); send(8'h00, ack); stop_c();
        start_c(); send(dev(0, 1'b0), ack); stop_c();
        chk("R5 address-only write, select acked", ack, 1);

        // R10 sequential read wraps at array end
        wbuf[0] = 8'hAB; wr(16'h7FF, 1, 1'b1, "R10");
        wbuf[0] = 8'hCD; wr(16'h000, 1, 1'b1, "R10");
        rd(16'h7FF, 2, "R10");
        chk("R10 last byte", rbuf[0], 8'hAB);
        chk("R10 wrapped to 0", rbuf[1], 8'hCD);
        chk("R10 released after NACK", int'(sda_oe), 0);

        // R12 upper half writable with wp low; R11 protection
        wbuf[0] = 8'h10; wr(16'h400, 1, 1'b1, "R12");
        wp = 1'b1;
        wbuf[0] = 8'h77; wr(16'h400, 1, 1'b1, "R11");
        wbuf[0] = 8'h66; wr(16'h3F0, 1, 1'b1, "R11");
        wp = 1'b0;
        rd(16'h400, 1, "R11");
        chk("R11 protected byte unchanged", rbuf[0], 8'h10);
        rd(16'h3F0, 1, "R11");
        chk("R11 lower half written", rbuf[0], 8'h66);

        // R3 mismatched code ignored until START
        start_c();
        send(8'hB0, ack); chk("R3 wrong code no ack", ack, 0);
        send(8'hA0, ack); chk("R3 ignored without START", ack, 0);
        stop_c();
        chk("R3 line released", int'(sda_oe), 0);

        // R2 STOP returns to idle
        start_c();
        send(dev(0, 1'b0), ack); chk("R2 select ack", ack, 1);
        stop_c();
        hw(H); m_scl = 1'b0; hw(H);
        send(8'hA0, ack); chk("R2 byte after STOP ignored", ack, 0);
        stop_c();
        chk("R1 idle after STOP", int'(sda_oe), 0);

        summary();
    end

endmodule